// File: doc/BRIEF.md
# Block Address Translator

This unit turns an effective address into a physical address for large, contiguous regions of memory. It does so without walking a page table. It holds eight programmable entries. Four are data entries and four are instruction entries, and each entry is an upper/lower register pair. An entry covers a power-of-two region of 128 KiB or more. The region size comes from a length mask in the upper register.

A request strobe, the effective address and the privilege mode are sampled on one clock edge. A hit flag and the translated address appear on the next edge. A miss means that no entry covers the address, and the surrounding logic must then fall back to paged translation. The entries are loaded through a narrow write port. Protection bits and cache attributes in the lower register are stored but not enforced.

Top module: `blk_xlate`

## Requirements
- R1: After reset, hit_o and pa_o are 0 and every register holds zero, so any request misses.
- R2: A write with wr_en_i=1 stores wr_data_i into one register. wr_idx_i selects the pair. wr_side_i selects the side: 0 is data, 1 is instruction. wr_upper_i selects the register: 1 is upper, 0 is lower. A write with wr_idx_i of 4 to 7 changes no register.
- R3: The upper register holds these fields:
  - bits [31:17]: the block page index.
  - bits [12:2]: the 11-bit length mask BL.
  - bit 1: the supervisor valid bit.
  - bit 0: the user valid bit.

  With user_i=1 only bit 0 qualifies an entry. With user_i=0 only bit 1 qualifies it.
- R4: An entry matches when two conditions hold. First, bits [31:17] of (ea_i AND (NOT(BL<<17) OR 0xF001FFFF)) must equal its block page index. Second, its selected valid bit must be 1.
- R5: On a hit, pa_o is built from three parts OR-ed together:
  - the lower register's bits [31:17], placed at bits [31:17];
  - ea_i AND (BL<<17);
  - ea_i[16:0].
- R6: Entries are tried in the order data 0, instruction 0, data 1, instruction 1, and so on up to instruction 3. The first entry that matches supplies the result.
- R7: When no entry matches, hit_o is 0 and pa_o is 0.
- R8: The result of a request sampled with req_i=1 appears on hit_o/pa_o after that edge. While req_i is 0, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Pair index for the write |
| wr_side_i | input | 1 | 0 data, 1 instruction |
| wr_upper_i | input | 1 | 1 upper register, 0 lower register |
| wr_data_i | input | 32 | Write data |
| req_i | input | 1 | Translation request strobe |
| ea_i | input | 32 | Effective address |
| user_i | input | 1 | 1 user mode, 0 supervisor mode |
| hit_o | output | 1 | Registered hit flag |
| pa_o | output | 32 | Registered physical address |

## Verification
The hardest case to reach is several entries covering the same address with different valid bits. In that case the result depends on both the priority order and the privilege mode. Purely random register contents almost never overlap. The stimulus therefore programs the data and instruction entries at one index over a shared region with complementary valid bits, then requests the region in both modes. The random phase draws each address from some entry's page index, with random bits placed under its length mask, so matches are frequent and the masked bits vary.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned PAGE_LO = 17;
  localparam int unsigned BL_W    = 11;
  localparam logic [AW-1:0] KEEP_MASK = 32'hF001_FFFF;
  typedef logic [AW-1:0] word_t;
endpackage

// File: rtl/blk_regs.sv
module blk_regs
  import blk_xlate_pkg::*;
#(
  parameter int unsigned N_PAIRS = 4,
  parameter int unsigned IDX_W   = 3,
  localparam int unsigned NE     = 2 * N_PAIRS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_side_i,
  input  logic             wr_upper_i,
  input  word_t            wr_data_i,
  output logic [NE-1:0][AW-1:0] upper_o,
  output logic [NE-1:0][AW-1:0] lower_o
);
  logic [NE-1:0][AW-1:0] up_q, lo_q;

  // entry k = 2*pair + side gives the lookup priority order
  for (genvar k = 0; k < NE; k++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (int'(wr_idx_i) == k / 2) && (wr_side_i == 1'(k % 2));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[k] <= '0;
        lo_q[k] <= '0;
      end else if (sel) begin
        if (wr_upper_i) up_q[k] <= wr_data_i;
        else            lo_q[k] <= wr_data_i;
      end
    end
  end

  assign upper_o = up_q;
  assign lower_o = lo_q;

  p_bad_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_idx_i) >= N_PAIRS) |=> ($stable(up_q) && $stable(lo_q)));
endmodule

// File: rtl/blk_entry.sv
module blk_entry
  import blk_xlate_pkg::*;
(
  input  word_t upper_i,
  input  word_t lower_i,
  input  word_t ea_i,
  input  logic  user_i,
  output logic  match_o,
  output word_t pa_o
);
  word_t len_mask, ea_cmp;
  logic  valid;

  assign len_mask = word_t'(upper_i[2 +: BL_W]) << PAGE_LO;
  assign ea_cmp   = ea_i & (~len_mask | KEEP_MASK);
  assign valid    = user_i ? upper_i[0] : upper_i[1];
  assign match_o  = valid && (ea_cmp[AW-1:PAGE_LO] == upper_i[AW-1:PAGE_LO]);
  assign pa_o     = {lower_i[AW-1:PAGE_LO], {PAGE_LO{1'b0}}}
                  | (ea_i & len_mask)
                  | {{(AW-PAGE_LO){1'b0}}, ea_i[PAGE_LO-1:0]};
endmodule

// File: rtl/blk_pick.sv
module blk_pick
  import blk_xlate_pkg::*;
#(
  parameter int unsigned NE = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NE-1:0]         match_i,
  input  logic [NE-1:0][AW-1:0] pa_i,
  output logic                  hit_o,
  output word_t                 pa_o
);
  logic [NE-1:0] grant;

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int k = 0; k < NE; k++) begin
      if (match_i[k] && !taken) begin
        grant[k] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    pa_o = '0;
    for (int k = 0; k < NE; k++) pa_o |= pa_i[k] & {AW{grant[k]}};
  end

  assign hit_o = |grant;

  p_one_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import blk_xlate_pkg::*;
#(
  parameter int unsigned N_PAIRS = 4,
  parameter int unsigned IDX_W   = 3,
  localparam int unsigned NE     = 2 * N_PAIRS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_side_i,
  input  logic             wr_upper_i,
  input  logic [31:0]      wr_data_i,
  input  logic             req_i,
  input  logic [31:0]      ea_i,
  input  logic             user_i,
  output logic             hit_o,
  output logic [31:0]      pa_o
);
  logic [NE-1:0][AW-1:0] upper, lower, ent_pa;
  logic [NE-1:0]         match;
  logic                  hit_d;
  word_t                 pa_d;

  blk_regs #(.N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_side_i, .wr_upper_i, .wr_data_i,
    .upper_o(upper), .lower_o(lower)
  );

  for (genvar k = 0; k < NE; k++) begin : g_cmp
    blk_entry u_ent (
      .upper_i(upper[k]), .lower_i(lower[k]), .ea_i(ea_i), .user_i(user_i),
      .match_o(match[k]), .pa_o(ent_pa[k])
    );
  end

  blk_pick #(.NE(NE)) u_pick (
    .clk_i, .rst_ni, .match_i(match), .pa_i(ent_pa), .hit_o(hit_d), .pa_o(pa_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      pa_o  <= '0;
    end else if (req_i) begin
      hit_o <= hit_d;
      pa_o  <= pa_d;
    end
  end

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(hit_o) && $stable(pa_o)));
  p_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!hit_o || pa_o[PAGE_LO-1:0] == $past(ea_i[PAGE_LO-1:0])));
endmodule

// File: tb/sim_blk_xlate.sv
module sim_blk_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_side = 0, wr_upper = 0, req = 0, user = 0;
  logic [2:0] wr_idx = '0;
  logic [31:0] wr_data = '0, ea = '0;
  logic hit;
  logic [31:0] pa;
  int checks = 0, fails = 0;
  logic [31:0] m_up [8];
  logic [31:0] m_lo [8];

  always #5 clk = ~clk;

  blk_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_side_i(wr_side), .wr_upper_i(wr_upper), .wr_data_i(wr_data),
    .req_i(req), .ea_i(ea), .user_i(user), .hit_o(hit), .pa_o(pa)
  );

  function automatic logic [32:0] ref_xlate(logic [31:0] a, logic u);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] blm, msk;
      logic v;
      blm = {4'h0, m_up[k][12:2], 17'h0};
      msk = a & (~blm | 32'hF001FFFF);
      v   = u ? m_up[k][0] : m_up[k][1];
      if (v && msk[31:17] == m_up[k][31:17])
        return {1'b1, ({m_lo[k][31:17], 17'h0} | (a & blm) | {15'h0, a[16:0]})};
    end
    return 33'h0;
  endfunction

  task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic side, logic upr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_side = side; wr_upper = upr; wr_data = d;
    if (idx < 4) begin
      if (upr) m_up[2*idx + int'(side)] = d;
      else     m_lo[2*idx + int'(side)] = d;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic xl(string tag, logic [31:0] a, logic u);
    @(negedge clk);
    req = 1; ea = a; user = u;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    check(tag, {hit, pa}, ref_xlate(a, u));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [32:0] held;
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) begin m_up[k] = '0; m_lo[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {hit, pa}, 33'h0);
    rst_n = 1;
    xl("R1 empty table misses", 32'h0000_0000, 1'b0);
    xl("R1 empty table misses user", 32'h8123_4567, 1'b1);

    // data 0: supervisor-only, 2 MiB block
    wr(0, 0, 0, 32'h0120_0000);
    wr(0, 0, 1, 32'h8000_0000 | (32'h00F << 2) | 32'h2);
    xl("R4 R5 supervisor hit masked bits", 32'h801A_3456, 1'b0);
    check("R5 masked bits carried", {hit, pa}, {1'b1, 32'h013A_3456});
    xl("R3 user valid clear misses", 32'h801A_3456, 1'b1);
    check("R7 miss gives zero", {hit, pa}, 33'h0);
    xl("R4 outside block misses", 32'h8020_0000, 1'b0);
    // instruction 0 overlaps, both modes valid
    wr(0, 1, 0, 32'h0440_0000);
    wr(0, 1, 1, 32'h8000_0000 | (32'h00F << 2) | 32'h3);
    xl("R6 data before instruction", 32'h8005_0000, 1'b0);
    check("R6 data wins", {hit, pa}, {1'b1, 32'h0125_0000});
    xl("R3 R6 user picks instruction", 32'h8005_0000, 1'b1);
    check("R3 instruction result", {hit, pa}, {1'b1, 32'h0445_0000});
    // data 1 overlaps too; index 0 wins
    wr(1, 0, 0, 32'h0F00_0000);
    wr(1, 0, 1, 32'h8000_0003);
    xl("R6 lower index wins", 32'h8001_0004, 1'b1);
    // writes at index 4..7 ignored
    wr(5, 0, 1, 32'h8000_0003);
    wr(4, 1, 0, 32'hFFFF_FFFF);
    wr(7, 0, 1, 32'h4000_0003);
    xl("R2 high index ignored", 32'h4000_0010, 1'b0);
    check("R2 no entry at 0x4000", {hit, pa}, 33'h0);
    xl("R2 entries unchanged", 32'h8005_0000, 1'b0);
    // hold while req low
    held = {hit, pa};
    @(negedge clk); ea = 32'h0; user = 1;
    @(negedge clk); @(negedge clk);
    check("R8 hold without req", {hit, pa}, held);

    for (int it = 0; it < 400; it++) begin
      logic [31:0] a, blm;
      int k;
      if ($urandom_range(0, 3) == 0) begin
        logic [31:0] d;
        int bits;
        bits = $urandom_range(0, 11);
        d = $urandom;
        d[12:2] = 11'((1 << bits) - 1);
        d[27:17] = d[27:17] & ~d[12:2];
        wr($urandom_range(0, 7), 1'($urandom), 1'b1, d);
        wr($urandom_range(0, 3), 1'($urandom), 1'b0, $urandom);
      end
      k = $urandom_range(0, 7);
      blm = {4'h0, m_up[k][12:2], 17'h0};
      a = {m_up[k][31:17], 17'h0} | ($urandom & blm) | ($urandom & 32'h1FFFF);
      if ($urandom_range(0, 4) == 0) a = $urandom;
      xl("R4 R5 R6 random", a, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule